// File: doc/BRIEF.md
# Oscillator and PLL Control Registers

This block holds the control state for four clock sources: a main crystal oscillator, a secondary crystal oscillator and two PLLs. Software programs it through a small 32-bit register bus (address, write strobe, write data, combinational read data). Every source is modelled as an effective enable plus a ready flag that rises after a programmable settling time and drops one cycle after the enable goes away. The main crystal and PLL1 are owned by hardware and stay running until software takes them over with an override bit. PLL2 and the secondary crystal follow their control bits directly.

A separate frequency register carries a multiplier for each PLL and a post-divider for PLL1. The block multiplies an input reference code by these fields and presents one frequency word per PLL. A reboot request input returns the main crystal to its hardware-owned, running state, whatever software last wrote. The bus has no back-pressure: a write is taken on every clock edge where the write strobe is high, and read data follows the address in the same cycle.

Top module: `osc_pll_ctrl`

## Requirements
- R1: After reset, offset 0x0C reads 0x0010_0002, offset 0x10 reads 0x2000_0000, offset 0x14 reads 0, `src_on` is 4'b0111 and `src_ready` is 0. The `src_*` bit order is {PLL2, PLL1, secondary crystal, main crystal}.
- R2: Offset 0x0C stores bit 0 as the main-crystal override, bit 1 as the main-crystal enable, bit 19 as the secondary-crystal disable and bit 20 as the crystal timer enable. Bit 2 reads the main-crystal ready flag. All other bits read 0.
- R3: The main crystal is on while its override (0x0C bit 0) is 0, whatever its enable bit holds. While the override is 1, the main crystal follows the enable bit (0x0C bit 1).
- R4: Offset 0x10 stores bit 0 as the PLL1 override, bit 1 as the PLL1 enable, bit 28 as the PLL2 enable and bit 29 as the PLL timer enable. Bit 2 reads the PLL1 ready flag. PLL1 is on while its override is 0 and follows its enable bit while its override is 1. PLL2 follows bit 28. The secondary crystal is on exactly when 0x0C bit 19 is 0.
- R5: Suppose a source's enable rises after the clock edge that takes a write, and its timer bit (0x0C bit 20 for the crystals, 0x10 bit 29 for the PLLs) is 1. Its ready flag then goes high max(`settle_cycles`, 1) edges after that write edge. With the timer bit at 0, the ready flag goes high after 1 edge.
- R6: A ready flag drops at the first clock edge at which its source's enable is low.
- R7: Offset 0x14 stores bits 13:8 (M1), bits 2:0 (D1) and bits 29:24 (M2), and its other bits read 0. `pll1_freq` = (`ref_code` × (M1+2)) >> D1 and `pll2_freq` = `ref_code` × (M2+2). Both are combinational.
- R8: A clock edge with `reboot_req` high leaves 0x0C bit 0 at 0 and bit 1 at 1, even when a write to 0x0C is taken at the same edge. The other bits of 0x0C keep the value they would otherwise have.
- R9: Reads of any offset other than 0x0C, 0x10 and 0x14 return 0. Writes to those other offsets change no register. A write to a ready-flag bit position has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_we | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| reboot_req | input | 1 | Forces the main crystal back to its hardware-owned running state |
| settle_cycles | input | CNT_W | Settling time in clock edges used when a timer bit is set |
| ref_code | input | REF_W | Reference frequency code |
| src_on | output | 4 | Effective enables {PLL2, PLL1, secondary, main} |
| src_ready | output | 4 | Ready flags, same order |
| pll1_freq | output | REF_W+7 | PLL1 frequency word |
| pll2_freq | output | REF_W+7 | PLL2 frequency word |

## Verification
The assertions run on every cycle. They check that a ready flag never outlives its enable by more than one edge and only rises after the enable was present. They check that reboot always leaves the main crystal on and that unmapped reads return zero. They also check that a read showing a cleared override implies a running source, and that the frequency words hold while nothing is written and the reference is steady. The exact settling latency for each count, the effect of the timer bits, the full sweep of multiplier and divider values, and reboot taking priority over a simultaneous write can only be shown by the bench scenarios. Those scenarios compare the outputs against arithmetic computed in the bench.

// File: rtl/osc_pll_pkg.sv
`timescale 1ns/1ps
package osc_pll_pkg;
  // register offsets (byte addresses)
  localparam int unsigned OFS_XTAL = 32'h0C;
  localparam int unsigned OFS_PLL  = 32'h10;
  localparam int unsigned OFS_FREQ = 32'h14;

  // crystal control bit positions
  localparam int XB_MX_OVER = 0;
  localparam int XB_MX_EN   = 1;
  localparam int XB_MX_RDY  = 2;
  localparam int XB_SX_DIS  = 19;
  localparam int XB_TIMER   = 20;

  // PLL control bit positions
  localparam int PB_P1_OVER = 0;
  localparam int PB_P1_EN   = 1;
  localparam int PB_P1_RDY  = 2;
  localparam int PB_P2_EN   = 28;
  localparam int PB_TIMER   = 29;

  // frequency field positions
  localparam int FB_D1_LO = 0;
  localparam int FB_M1_LO = 8;
  localparam int FB_M2_LO = 24;
  localparam int MUL_W    = 6;
  localparam int DIV_W    = 3;

  // source indices
  localparam int SRC_MX  = 0;
  localparam int SRC_SX  = 1;
  localparam int SRC_P1  = 2;
  localparam int SRC_P2  = 3;
  localparam int NUM_SRC = 4;

  typedef struct packed {
    logic             mx_over;
    logic             mx_en;
    logic             sx_dis;
    logic             xt_timer;
    logic             p1_over;
    logic             p1_en;
    logic             p2_en;
    logic             pl_timer;
    logic [MUL_W-1:0] m1;
    logic [DIV_W-1:0] d1;
    logic [MUL_W-1:0] m2;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{
    mx_over: 1'b0, mx_en: 1'b1, sx_dis: 1'b0, xt_timer: 1'b1,
    p1_over: 1'b0, p1_en: 1'b0, p2_en: 1'b0, pl_timer: 1'b1,
    m1: '0, d1: '0, m2: '0
  };
endpackage

// File: rtl/osc_pll_regs.sv
`timescale 1ns/1ps
module osc_pll_regs
  import osc_pll_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  input  logic              reboot_req,
  output ctrl_t             ctrl
);
  logic wr_xtal, wr_pll, wr_freq;
  logic unused_wbits;

  assign wr_xtal = bus_we && (bus_addr == ADDR_W'(OFS_XTAL));
  assign wr_pll  = bus_we && (bus_addr == ADDR_W'(OFS_PLL));
  assign wr_freq = bus_we && (bus_addr == ADDR_W'(OFS_FREQ));
  assign unused_wbits = ^{bus_wdata[31:30], bus_wdata[23:21],
                          bus_wdata[18:14], bus_wdata[7:3]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= CTRL_RESET;
    end else begin
      if (wr_xtal) begin
        ctrl.mx_over  <= bus_wdata[XB_MX_OVER];
        ctrl.mx_en    <= bus_wdata[XB_MX_EN];
        ctrl.sx_dis   <= bus_wdata[XB_SX_DIS];
        ctrl.xt_timer <= bus_wdata[XB_TIMER];
      end
      if (wr_pll) begin
        ctrl.p1_over  <= bus_wdata[PB_P1_OVER];
        ctrl.p1_en    <= bus_wdata[PB_P1_EN];
        ctrl.p2_en    <= bus_wdata[PB_P2_EN];
        ctrl.pl_timer <= bus_wdata[PB_TIMER];
      end
      if (wr_freq) begin
        ctrl.m1 <= bus_wdata[FB_M1_LO +: MUL_W];
        ctrl.d1 <= bus_wdata[FB_D1_LO +: DIV_W];
        ctrl.m2 <= bus_wdata[FB_M2_LO +: MUL_W];
      end
      // reboot wins over a same-edge software write
      if (reboot_req) begin
        ctrl.mx_over <= 1'b0;
        ctrl.mx_en   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/osc_settle.sv
`timescale 1ns/1ps
module osc_settle #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             timer_on,
  input  logic [CNT_W-1:0] settle_cycles,
  output logic             ready
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cnt_nxt;
  logic             done;

  assign cnt_nxt = {1'b0, cnt} + 1'b1;
  assign done    = !timer_on || (cnt_nxt >= {1'b0, settle_cycles});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!en) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      if (done) ready <= 1'b1;
      if (!cnt_nxt[CNT_W]) cnt <= cnt_nxt[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/osc_pll_freq.sv
`timescale 1ns/1ps
module osc_pll_freq
  import osc_pll_pkg::*;
#(
  parameter int REF_W = 12
) (
  input  logic [REF_W-1:0] ref_code,
  input  logic [MUL_W-1:0] m1,
  input  logic [DIV_W-1:0] d1,
  input  logic [MUL_W-1:0] m2,
  output logic [REF_W+6:0] pll1_freq,
  output logic [REF_W+6:0] pll2_freq
);
  localparam int FW = REF_W + 7;

  logic [FW-1:0] mul1, mul2, prod1;

  assign mul1      = FW'(m1) + FW'(2);
  assign mul2      = FW'(m2) + FW'(2);
  assign prod1     = FW'(ref_code) * mul1;
  assign pll1_freq = prod1 >> d1;
  assign pll2_freq = FW'(ref_code) * mul2;
endmodule

// File: rtl/osc_pll_ctrl.sv
`timescale 1ns/1ps
module osc_pll_ctrl
  import osc_pll_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8,
  parameter int REF_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              reboot_req,
  input  logic [CNT_W-1:0]  settle_cycles,
  input  logic [REF_W-1:0]  ref_code,
  output logic [3:0]        src_on,
  output logic [3:0]        src_ready,
  output logic [REF_W+6:0]  pll1_freq,
  output logic [REF_W+6:0]  pll2_freq
);
  ctrl_t              ctrl;
  logic [NUM_SRC-1:0] timer_sel;

  osc_pll_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .reboot_req(reboot_req), .ctrl(ctrl)
  );

  // hardware-owned sources run until the override hands them to software
  assign src_on[SRC_MX] = ctrl.mx_over ? ctrl.mx_en : 1'b1;
  assign src_on[SRC_SX] = !ctrl.sx_dis;
  assign src_on[SRC_P1] = ctrl.p1_over ? ctrl.p1_en : 1'b1;
  assign src_on[SRC_P2] = ctrl.p2_en;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (i == SRC_MX || i == SRC_SX) begin : g_xt
        assign timer_sel[i] = ctrl.xt_timer;
      end else begin : g_pl
        assign timer_sel[i] = ctrl.pl_timer;
      end
      osc_settle #(.CNT_W(CNT_W)) u_settle (
        .clk(clk), .rst_n(rst_n), .en(src_on[i]), .timer_on(timer_sel[i]),
        .settle_cycles(settle_cycles), .ready(src_ready[i])
      );
    end
  endgenerate

  osc_pll_freq #(.REF_W(REF_W)) u_freq (
    .ref_code(ref_code), .m1(ctrl.m1), .d1(ctrl.d1), .m2(ctrl.m2),
    .pll1_freq(pll1_freq), .pll2_freq(pll2_freq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_XTAL)) begin
      bus_rdata[XB_MX_OVER] = ctrl.mx_over;
      bus_rdata[XB_MX_EN]   = ctrl.mx_en;
      bus_rdata[XB_MX_RDY]  = src_ready[SRC_MX];
      bus_rdata[XB_SX_DIS]  = ctrl.sx_dis;
      bus_rdata[XB_TIMER]   = ctrl.xt_timer;
    end else if (bus_addr == ADDR_W'(OFS_PLL)) begin
      bus_rdata[PB_P1_OVER] = ctrl.p1_over;
      bus_rdata[PB_P1_EN]   = ctrl.p1_en;
      bus_rdata[PB_P1_RDY]  = src_ready[SRC_P1];
      bus_rdata[PB_P2_EN]   = ctrl.p2_en;
      bus_rdata[PB_TIMER]   = ctrl.pl_timer;
    end else if (bus_addr == ADDR_W'(OFS_FREQ)) begin
      bus_rdata[FB_M1_LO +: MUL_W] = ctrl.m1;
      bus_rdata[FB_D1_LO +: DIV_W] = ctrl.d1;
      bus_rdata[FB_M2_LO +: MUL_W] = ctrl.m2;
    end
  end
endmodule

// File: rtl/osc_pll_chk.sv
`timescale 1ns/1ps
module osc_pll_chk
  import osc_pll_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int REF_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_rdata,
  input logic              reboot_req,
  input logic [REF_W-1:0]  ref_code,
  input logic [3:0]        src_on,
  input logic [3:0]        src_ready,
  input logic [REF_W+6:0]  pll1_freq,
  input logic [REF_W+6:0]  pll2_freq
);
  logic mapped;
  assign mapped = (bus_addr == ADDR_W'(OFS_XTAL)) || (bus_addr == ADDR_W'(OFS_PLL)) ||
                  (bus_addr == ADDR_W'(OFS_FREQ));

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
      p_ready_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !src_on[i] |=> !src_ready[i]);
      p_ready_after_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_ready[i]) |-> $past(src_on[i]));
    end
  endgenerate

  p_reboot_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_req |=> src_on[SRC_MX]);

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (bus_rdata == 32'd0));

  p_mx_hw_owned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_addr == ADDR_W'(OFS_XTAL)) && !bus_rdata[XB_MX_OVER]) |-> src_on[SRC_MX]);

  p_p1_hw_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_addr == ADDR_W'(OFS_PLL)) && !bus_rdata[PB_P1_OVER]) |-> src_on[SRC_P1]);

  p_freq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && $stable(ref_code)) |=> ($stable(pll1_freq) && $stable(pll2_freq)));
endmodule

bind osc_pll_ctrl osc_pll_chk #(.ADDR_W(ADDR_W), .REF_W(REF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_rdata(bus_rdata), .reboot_req(reboot_req), .ref_code(ref_code),
  .src_on(src_on), .src_ready(src_ready), .pll1_freq(pll1_freq),
  .pll2_freq(pll2_freq)
);

// File: tb/test_osc_pll_ctrl.sv
`timescale 1ns/1ps
module test_osc_pll_ctrl;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = 8;
  localparam int REF_W  = 12;
  localparam int FW     = REF_W + 7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_we = 1'b0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              reboot_req = 1'b0;
  logic [CNT_W-1:0]  settle_cycles = 8'd3;
  logic [REF_W-1:0]  ref_code = '0;
  logic [3:0]        src_on, src_ready;
  logic [FW-1:0]     pll1_freq, pll2_freq;

  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  osc_pll_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REF_W(REF_W)) i_osc_pll_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .reboot_req(reboot_req),
    .settle_cycles(settle_cycles), .ref_code(ref_code), .src_on(src_on),
    .src_ready(src_ready), .pll1_freq(pll1_freq), .pll2_freq(pll2_freq)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit rb);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; reboot_req = rb;
    @(posedge clk);
    #1;
    bus_we = 1'b0; reboot_req = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  // measure edges from the enabling write to the rising ready flag
  task automatic settle(input int idx, input logic [7:0] a, input logic [31:0] off_d,
                        input logic [31:0] on_d, input int n, input int exp, input string req);
    int cnt;
    settle_cycles = CNT_W'(n);
    wr(a, off_d, 1'b0);
    idle(2);
    check(src_on[idx] == 1'b0 && src_ready[idx] == 1'b0, req, {src_on[idx], src_ready[idx]}, 0);
    wr(a, on_d, 1'b0);
    cnt = 0;
    while (!src_ready[idx] && cnt < 60) begin
      @(posedge clk);
      #1;
      cnt++;
    end
    check(cnt == exp, req, cnt, exp);
  endtask

  logic [31:0] r, rx, rp, rf;

  initial begin
    #(5.0 * 150000);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #12;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state, before any active edge
    check(src_on == 4'b0111, "R1 src_on", src_on, 4'b0111);
    check(src_ready == 4'b0000, "R1 src_ready", src_ready, 0);
    bus_addr = 8'h0C; #0.1;
    check(bus_rdata == 32'h0010_0002, "R1 xtal", bus_rdata, 32'h0010_0002);
    bus_addr = 8'h10; #0.1;
    check(bus_rdata == 32'h2000_0000, "R1 pll", bus_rdata, 32'h2000_0000);
    bus_addr = 8'h14; #0.1;
    check(bus_rdata == 32'h0, "R1 freq", bus_rdata, 0);

    // R5: hardware-owned sources settle after reset (settle=3)
    idle(4);
    check(src_ready == 4'b0111, "R5 after reset", src_ready, 4'b0111);

    // R3: main crystal ownership
    wr(8'h0C, 32'h0010_0000, 1'b0);
    check(src_on[0] == 1'b1, "R3 no override, enable 0", src_on[0], 1);
    wr(8'h0C, 32'h0010_0001, 1'b0);
    check(src_on[0] == 1'b0, "R3 override, enable 0", src_on[0], 0);
    wr(8'h0C, 32'h0010_0003, 1'b0);
    check(src_on[0] == 1'b1, "R3 override, enable 1", src_on[0], 1);

    // R4: PLL1, PLL2, secondary control
    wr(8'h10, 32'h2000_0000, 1'b0);
    check(src_on[2] == 1'b1 && src_on[3] == 1'b0, "R4 pll default", src_on, 4'b0111);
    wr(8'h10, 32'h2000_0001, 1'b0);
    check(src_on[2] == 1'b0, "R4 pll1 override off", src_on[2], 0);
    wr(8'h10, 32'h3000_0002, 1'b0);
    check(src_on[2] == 1'b1 && src_on[3] == 1'b1, "R4 pll1 hw + pll2 on", src_on[3:2], 2'b11);
    wr(8'h0C, 32'h0018_0002, 1'b0);
    check(src_on[1] == 1'b0, "R4 secondary disabled", src_on[1], 0);
    wr(8'h0C, 32'h0010_0002, 1'b0);
    check(src_on[1] == 1'b1, "R4 secondary enabled", src_on[1], 1);

    // R2: crystal register layout
    wr(8'h0C, 32'hFFFF_FFFB, 1'b0);
    idle(6);
    rd(8'h0C, r);
    check(r == 32'h0018_0007, "R2 xtal all ones", r, 32'h0018_0007);

    // R6: ready drops one edge after enable falls
    settle_cycles = 8'd2;
    wr(8'h10, 32'h3000_0003, 1'b0);
    idle(4);
    wr(8'h10, 32'h2000_0003, 1'b0);
    check(src_on[3] == 1'b0 && src_ready[3] == 1'b1, "R6 pll2 before edge", {src_on[3], src_ready[3]}, 1);
    idle(1);
    check(src_ready[3] == 1'b0, "R6 pll2 after edge", src_ready[3], 0);
    wr(8'h0C, 32'h0010_0001, 1'b0);
    check(src_ready[0] == 1'b1, "R6 mx before edge", src_ready[0], 1);
    idle(1);
    check(src_ready[0] == 1'b0, "R6 mx after edge", src_ready[0], 0);

    // R5: settling sweep for all four sources
    for (int n = 0; n < 7; n++) begin
      int e;
      e = (n < 1) ? 1 : n;
      settle(0, 8'h0C, 32'h0010_0001, 32'h0010_0003, n, e, "R5 main crystal");
      settle(1, 8'h0C, 32'h0018_0002, 32'h0010_0002, n, e, "R5 secondary crystal");
      settle(2, 8'h10, 32'h2000_0001, 32'h2000_0003, n, e, "R5 pll1");
      settle(3, 8'h10, 32'h2000_0003, 32'h3000_0003, n, e, "R5 pll2");
    end
    // R5: timer bits cleared, settle count ignored
    settle(0, 8'h0C, 32'h0000_0001, 32'h0000_0003, 6, 1, "R5 crystal timer off");
    settle(3, 8'h10, 32'h0000_0003, 32'h1000_0003, 6, 1, "R5 pll timer off");
    // R5: large count
    settle(2, 8'h10, 32'h2000_0001, 32'h2000_0003, 40, 40, "R5 pll1 count 40");

    // R9: ready-flag bit writes ignored
    settle_cycles = 8'd1;
    wr(8'h10, 32'h3000_0003, 1'b0);
    idle(3);
    wr(8'h10, 32'hFFFF_FFFF, 1'b0);
    rd(8'h10, r);
    check(r == 32'h3000_0007, "R9 pll all ones", r, 32'h3000_0007);
    wr(8'h10, 32'h2000_0005, 1'b0);
    idle(2);
    rd(8'h10, r);
    check(r == 32'h2000_0001, "R9 status not writable", r, 32'h2000_0001);

    // R9: unmapped reads and writes
    wr(8'h14, 32'h1500_2A03, 1'b0);
    rd(8'h0C, rx); rd(8'h10, rp); rd(8'h14, rf);
    for (int a = 0; a < 256; a += 4) begin
      if (a != 8'h0C && a != 8'h10 && a != 8'h14) begin
        wr(8'(a), 32'hFFFF_FFFF, 1'b0);
        rd(8'(a), r);
        check(r == 32'h0, "R9 unmapped read", r, 0);
      end
    end
    rd(8'h0D, r);
    check(r == 32'h0, "R9 misaligned read", r, 0);
    rd(8'h0C, r); check(r == rx, "R9 xtal unchanged", r, rx);
    rd(8'h10, r); check(r == rp, "R9 pll unchanged", r, rp);
    rd(8'h14, r); check(r == rf, "R9 freq unchanged", r, rf);

    // R8: reboot request
    wr(8'h0C, 32'h0018_0001, 1'b0);
    check(src_on[0] == 1'b0, "R8 setup off", src_on[0], 0);
    wr(8'h0C, 32'h0018_0001, 1'b1);
    rd(8'h0C, r);
    check(r[1:0] == 2'b10 && r[19] == 1'b1 && r[20] == 1'b1, "R8 reboot over write", r, 32'h0018_0002);
    check(src_on[0] == 1'b1, "R8 main on", src_on[0], 1);
    wr(8'h0C, 32'h0000_0001, 1'b0);
    wr(8'h10, 32'h0000_0000, 1'b1);
    rd(8'h0C, r);
    check(r[1:0] == 2'b10 && r[20:19] == 2'b00, "R8 reboot alone", r, 32'h0000_0002);

    // R7: frequency sweep
    for (int rv = 0; rv < 3; rv++) begin
      ref_code = (rv == 0) ? 12'd1 : (rv == 1) ? 12'd1000 : 12'hFFF;
      for (int m = 0; m < 64; m++) begin
        for (int d = 0; d < 8; d++) begin
          longint e1, e2;
          int m2;
          m2 = (m ^ 6'h2A) & 63;
          wr(8'h14, (32'(m2) << 24) | (32'(m) << 8) | 32'(d) | 32'hC0C0_00F8, 1'b0);
          e1 = (longint'(ref_code) * (m + 2)) >>> d;
          e2 = longint'(ref_code) * (m2 + 2);
          check(pll1_freq == FW'(e1), "R7 pll1 freq", pll1_freq, e1);
          check(pll2_freq == FW'(e2), "R7 pll2 freq", pll2_freq, e2);
          if (m == 63 && d == 7) begin
            rd(8'h14, r);
            check(r == ((32'(m2) << 24) | (32'(m) << 8) | 32'(d)), "R7 freq readback", r,
                  (32'(m2) << 24) | (32'(m) << 8) | 32'(d));
          end
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule